// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple host port and a 16-bit single-data-rate SDRAM with four banks. The host offers one access at a time through a valid/ready handshake. Each access carries a read/write flag, a bank/row/column address, write data and a two-bit byte enable. The controller turns the access into an ACTIVE command followed by a READ or WRITE command. That column command always asks for auto-precharge, so no row is ever left open between accesses. Read data comes back on a response port together with a one-cycle valid strobe.

After reset the controller runs the device's start-up sequence on its own. It first issues a parameterised number of NOP cycles. It then closes all banks, issues two REFRESH commands and loads the mode register with burst length 1, sequential ordering and the chosen CAS latency. The host is held off until this sequence has finished. From then on, an interval timer raises refresh requests, and a pending refresh is always issued before the next host access.

All memory-side outputs come straight from flip-flops. The bidirectional data bus is split into an output word, an output enable and an input word, so that the pad can be built outside this block.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is high, the block holds CKE low, CS# high, the output enable low and host ready low. From the first clock after reset is released, CKE is high.
- R2: After reset, the block issues at least INIT_CYC cycles of NOP before its first command. No ACTIVE, READ or WRITE appears before host ready has been high once.
- R3: The start-up commands come in this order: PRECHARGE with address bit 10 = 1, REFRESH, REFRESH, then LOAD MODE REGISTER on bank 0. The mode-register address word places the burst length code 000 in bits 2:0, the sequential-order bit 0 in bit 3, and CAS_LAT in bits 6:4. All other bits of that word are 0.
- R4: Host ready is high only when the controller is idle after start-up and no refresh is pending. Ready is low in the cycle after a request is accepted, and it stays low until the access sequence is over.
- R5: Commands are coded on {RAS#, CAS#, WE#} with CS# low: 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE REGISTER. A WRITE followed by a READ of the same location returns the written word.
- R6: ACTIVE carries the request bank on the bank select and the request row on the address bus. The column command carries the column in the low COL_W address bits. The same row and column in different banks are separate locations.
- R7: On a WRITE, mask bit 0 (low byte, data bits 7:0) is the inverse of byte enable bit 0, and mask bit 1 (high byte, bits 15:8) is the inverse of byte enable bit 1. A masked byte keeps its earlier contents.
- R8: Every READ and WRITE drives address bit 10 high, which requests auto-precharge.
- R9: The column command follows its ACTIVE by exactly T_RCD cycles, with only NOPs in between.
- R10: Each READ gives exactly one one-cycle response strobe. The strobe captures the data bus on the edge that comes CAS_LAT cycles after the device samples the READ, so it is seen CAS_LAT+1 cycles after the READ command cycle.
- R11: The data output enable is high in WRITE command cycles and in no others.
- R12: After start-up, a REFRESH is issued once every REFI cycles. At least T_RC cycles pass from any REFRESH to the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | DATA_W | Read data |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank select |
| mem_addr | output | ROW_W | Address bus |
| mem_dqm | output | DATA_W/8 | Byte masks, bit 0 low byte, bit 1 high byte |
| mem_dq_out | output | DATA_W | Data to the device |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data from the device |

## Verification
The hardest case to reach from the ports is a refresh timer that expires while host requests keep arriving. In that case the pending refresh must take priority over the next access, and it must still hold its full recovery spacing. The bench reaches this case by running a long table of back-to-back accesses with a short refresh interval, and then by leaving the port idle across several intervals. Its device model measures the gap from each REFRESH to the next command. The read latency is checked just as tightly. The model drives the read word onto the bus for one cycle only, in the cycle the CAS latency calls for. A strobe that comes one cycle early or late therefore captures a poison value.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {RAS#, CAS#, WE#} command codes
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_PREALL,
    ST_REF1,
    ST_REF2,
    ST_LMR,
    ST_IDLE,
    ST_COL,
    ST_WAIT
  } ctl_state_e;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REFI = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int CW = (REFI > 1) ? $clog2(REFI) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFI - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      pending <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  // stage k high: the READ left the pins k+1 cycles ago
  logic [CAS_LAT-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      stage     <= (stage << 1) | CAS_LAT'(rd_issued);
      rsp_valid <= stage[CAS_LAT-1];
      if (stage[CAS_LAT-1]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 10,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int INIT_CYC = 100,
  parameter int REFI     = 780,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RC     = 7,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int CAS_LAT  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic [COL_W-1:0]       req_col,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   mem_cke,
  output logic                   mem_cs_n,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_we_n,
  output logic [BANK_W-1:0]      mem_ba,
  output logic [ROW_W-1:0]       mem_addr,
  output logic [DATA_W/8-1:0]    mem_dqm,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);
  localparam int BE_W   = DATA_W / 8;
  localparam int AP_BIT = 10;
  localparam int SPAN   = INIT_CYC + T_RC + T_RP + T_WR + CAS_LAT + T_MRD + T_RCD;
  localparam int CNT_W  = $clog2(SPAN + 1);
  // a wait loaded with G gives command-to-command spacing of G+2
  localparam logic [CNT_W-1:0] G_RP   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] G_RC   = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] G_MRD  = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] G_RCD  = CNT_W'(T_RCD - 2);
  localparam logic [CNT_W-1:0] G_RDP  = CNT_W'(CAS_LAT + T_RP - 2);
  localparam logic [CNT_W-1:0] G_WRP  = CNT_W'(T_WR + T_RP - 2);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  ctl_state_e state, after;
  logic [CNT_W-1:0] cnt;
  sdr_cmd_e cmd_q;
  logic cs_n_q, cke_q, oe_q, init_done;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BE_W-1:0]   dqm_q;
  logic [DATA_W-1:0] dq_q;

  logic              l_wr;
  logic [BANK_W-1:0] l_bank;
  logic [COL_W-1:0]  l_col;
  logic [DATA_W-1:0] l_data;
  logic [BE_W-1:0]   l_be;

  logic ref_pend, ref_ack, rd_issued;

  assign ref_ack   = (state == ST_IDLE) && ref_pend;
  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign rd_issued = !cs_n_q && (cmd_q == CMD_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      after     <= ST_IDLE;
      cnt       <= CNT_W'(INIT_CYC - 1);
      cmd_q     <= CMD_NOP;
      cs_n_q    <= 1'b1;
      cke_q     <= 1'b0;
      oe_q      <= 1'b0;
      init_done <= 1'b0;
      ba_q      <= '0;
      addr_q    <= '0;
      dqm_q     <= '1;
      dq_q      <= '0;
      l_wr      <= 1'b0;
      l_bank    <= '0;
      l_col     <= '0;
      l_data    <= '0;
      l_be      <= '0;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_NOP;
      cs_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dqm_q  <= '0;
      unique case (state)
        ST_INIT: begin
          if (cnt == '0) state <= ST_PREALL;
          else           cnt   <= cnt - 1'b1;
        end
        ST_PREALL: begin
          cmd_q <= CMD_PRE; cs_n_q <= 1'b0;
          addr_q <= '0; addr_q[AP_BIT] <= 1'b1;
          state <= ST_WAIT; after <= ST_REF1; cnt <= G_RP;
        end
        ST_REF1: begin
          cmd_q <= CMD_REF; cs_n_q <= 1'b0;
          state <= ST_WAIT; after <= ST_REF2; cnt <= G_RC;
        end
        ST_REF2: begin
          cmd_q <= CMD_REF; cs_n_q <= 1'b0;
          state <= ST_WAIT; after <= ST_LMR; cnt <= G_RC;
        end
        ST_LMR: begin
          cmd_q <= CMD_LMR; cs_n_q <= 1'b0;
          ba_q <= '0; addr_q <= MODE_WORD; init_done <= 1'b1;
          state <= ST_WAIT; after <= ST_IDLE; cnt <= G_MRD;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF; cs_n_q <= 1'b0;
            state <= ST_WAIT; after <= ST_IDLE; cnt <= G_RC;
          end else if (req_valid) begin
            l_wr   <= req_write;
            l_bank <= req_bank;
            l_col  <= req_col;
            l_data <= req_wdata;
            l_be   <= req_be;
            cmd_q  <= CMD_ACT; cs_n_q <= 1'b0;
            ba_q   <= req_bank; addr_q <= req_row;
            state  <= ST_WAIT; after <= ST_COL; cnt <= G_RCD;
          end
        end
        ST_COL: begin
          cmd_q  <= l_wr ? CMD_WR : CMD_RD; cs_n_q <= 1'b0;
          ba_q   <= l_bank;
          addr_q <= ROW_W'(l_col); addr_q[AP_BIT] <= 1'b1;
          if (l_wr) begin
            oe_q  <= 1'b1;
            dq_q  <= l_data;
            dqm_q <= ~l_be;
          end
          state <= ST_WAIT; after <= ST_IDLE;
          cnt   <= l_wr ? G_WRP : G_RDP;
        end
        default: begin // ST_WAIT
          if (cnt == '0) state <= after;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  sdram_ref_timer #(.REFI(REFI)) u_ref_timer (
    .clk     (clk),
    .rst     (rst),
    .enable  (init_done),
    .ack     (ref_ack),
    .pending (ref_pend)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rd_capture (
    .clk       (clk),
    .rst       (rst),
    .rd_issued (rd_issued),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign mem_cke    = cke_q;
  assign mem_cs_n   = cs_n_q;
  assign mem_ras_n  = cmd_q[2];
  assign mem_cas_n  = cmd_q[1];
  assign mem_we_n   = cmd_q[0];
  assign mem_ba     = ba_q;
  assign mem_addr   = addr_q;
  assign mem_dqm    = dqm_q;
  assign mem_dq_out = dq_q;
  assign mem_dq_oe  = oe_q;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_cs_n,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic [ROW_W-1:0] mem_addr,
  input logic             mem_dq_oe
);
  logic [2:0] pins;
  logic       seen_ready;
  assign pins = {mem_ras_n, mem_cas_n, mem_we_n};

  always_ff @(posedge clk) begin
    if (rst)            seen_ready <= 1'b0;
    else if (req_ready) seen_ready <= 1'b1;
  end

  assert_no_access_early_R2: assert property (@(posedge clk) disable iff (rst)
    (!seen_ready && !mem_cs_n) |-> (pins != 3'b011 && pins != 3'b101 && pins != 3'b100));

  assert_ready_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_autoprecharge_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && (pins == 3'b101 || pins == 3'b100)) |-> mem_addr[10]);

  assert_act_then_nop_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && pins == 3'b011) |=> mem_cs_n);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_oe_in_write_R11: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_cs_n && pins == 3'b100));

  assert_write_drives_R11: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && pins == 3'b100) |-> mem_dq_oe);
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module test_sdram_cmd_ctrl;
  localparam int INIT_CYC = 50;
  localparam int REFI     = 150;
  localparam int T_RCD    = 3;
  localparam int T_RP     = 2;
  localparam int T_RC     = 6;
  localparam int CL       = 3;

  typedef struct packed {
    logic        wr;
    logic [1:0]  ba;
    logic [12:0] row;
    logic [9:0]  col;
    logic [15:0] d;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam logic [59:0] VEC [NV] = '{
    {1'b1, 2'd0, 13'd5,    10'd3,    16'hA5A5, 2'b11, 16'h0000},
    {1'b1, 2'd3, 13'h1FFF, 10'h3FF,  16'h1234, 2'b11, 16'h0000},
    {1'b0, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b11, 16'hA5A5},
    {1'b0, 2'd3, 13'h1FFF, 10'h3FF,  16'h0000, 2'b11, 16'h1234},
    {1'b1, 2'd0, 13'd5,    10'd3,    16'hBEEF, 2'b01, 16'h0000},
    {1'b0, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b11, 16'hA5EF},
    {1'b1, 2'd0, 13'd5,    10'd3,    16'h7700, 2'b10, 16'h0000},
    {1'b0, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b11, 16'h77EF},
    {1'b1, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b00, 16'h0000},
    {1'b0, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b11, 16'h77EF},
    {1'b1, 2'd2, 13'd5,    10'd3,    16'h0102, 2'b11, 16'h0000},
    {1'b0, 2'd0, 13'd5,    10'd3,    16'h0000, 2'b11, 16'h77EF},
    {1'b0, 2'd2, 13'd5,    10'd3,    16'h0000, 2'b11, 16'h0102}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0, req_be = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [15:0] req_wdata = '0, mem_dq_in = 16'hDEAD;
  logic req_ready, rsp_valid, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_data, mem_dq_out;
  logic [1:0] mem_ba, mem_dqm;
  logic [12:0] mem_addr;

  always #5 clk = ~clk;

  sdram_cmd_ctrl #(.INIT_CYC(INIT_CYC), .REFI(REFI), .T_RCD(T_RCD), .T_RP(T_RP),
                   .T_RC(T_RC), .CAS_LAT(CL)) i_sdram_cmd_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_dqm(mem_dqm),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model, sampled at the falling edge ----------------
  logic [15:0] mem_m [logic [24:0]];
  logic [12:0] open_row [4];
  bit          open_v [4];
  int cyc = 0, n_cmds = 0, nop_pre = 0, early = 0, seq_bad_a10 = 0;
  logic [2:0] seq [4];
  bit seq_a10 = 0;
  logic [12:0] mode_word = '1;
  logic [1:0]  mode_ba = '1;
  int rd_cnt = 0, rd_cyc = 0, act_cyc = 0;
  bit drv_on = 0, seen_ready = 0, have_ref = 0;
  logic [15:0] rd_val = '0;
  int rsp_cnt = 0, rd_issued = 0, lat_bad = 0, oe_bad = 0, a10_bad = 0;
  int rcd_bad = 0, rcd_seen = 0, seq_bad = 0, ref_cnt = 0, last_ref = 0, min_gap = 1000;
  logic [1:0] last_dqm = '0;

  always @(negedge clk) begin
    if (!rst) begin
      logic [2:0] c;
      logic [24:0] key;
      logic [15:0] old;
      cyc++;
      if (drv_on) begin mem_dq_in = 16'hDEAD; drv_on = 0; end
      if (rd_cnt != 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin mem_dq_in = rd_val; drv_on = 1; end
      end
      if (rsp_valid) begin
        rsp_cnt++;
        if (cyc - rd_cyc != CL + 1) lat_bad++;
      end
      c = {mem_ras_n, mem_cas_n, mem_we_n};
      if (mem_dq_oe != (!mem_cs_n && c == 3'b100)) oe_bad++;
      if (mem_cs_n || c == 3'b111) begin
        if (n_cmds == 0) nop_pre++;
      end else begin
        if (n_cmds < 4) seq[n_cmds] = c;
        if (n_cmds == 0) seq_a10 = mem_addr[10];
        if (have_ref) begin
          if (cyc - last_ref < min_gap) min_gap = cyc - last_ref;
          have_ref = 0;
        end
        n_cmds++;
        if (!seen_ready && (c == 3'b011 || c == 3'b101 || c == 3'b100)) early++;
        case (c)
          3'b011: begin open_row[mem_ba] = mem_addr; open_v[mem_ba] = 1; act_cyc = cyc; end
          3'b101, 3'b100: begin
            if (!open_v[mem_ba]) seq_bad++;
            if (!mem_addr[10]) a10_bad++;
            rcd_seen++;
            if (cyc - act_cyc != T_RCD) rcd_bad++;
            key = {mem_ba, open_row[mem_ba], mem_addr[9:0]};
            old = mem_m.exists(key) ? mem_m[key] : 16'h0000;
            if (c == 3'b100) begin
              last_dqm = mem_dqm;
              if (!mem_dqm[0]) old[7:0]  = mem_dq_out[7:0];
              if (!mem_dqm[1]) old[15:8] = mem_dq_out[15:8];
              mem_m[key] = old;
            end else begin
              rd_val = old; rd_cnt = CL; rd_cyc = cyc; rd_issued++;
            end
            if (mem_addr[10]) open_v[mem_ba] = 0;
          end
          3'b001: begin ref_cnt++; last_ref = cyc; have_ref = 1; end
          3'b010: if (mem_addr[10]) for (int b = 0; b < 4; b++) open_v[b] = 0;
          3'b000: begin mode_word = mem_addr; mode_ba = mem_ba; end
          default: seq_bad++;
        endcase
      end
      if (req_ready) seen_ready = 1;
    end
  end

  // ---------------- host driver ----------------
  task automatic access(input vec_t v);
    int t;
    bit got;
    logic [15:0] data;
    req_write = v.wr; req_bank = v.ba; req_row = v.row; req_col = v.col;
    req_wdata = v.d;  req_be = v.be;   req_valid = 1'b1;
    t = 0;
    while (!req_ready && t < 5000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R4 ready low after accept", req_ready, 0);
    got = 0; data = '0; t = 0;
    forever begin
      if (rsp_valid) begin got = 1; data = rsp_data; end
      if (req_ready || t > 5000) break;
      @(negedge clk); t++;
    end
    if (v.wr) begin
      chk(last_dqm == ~v.be, "R7 byte masks", last_dqm, ~v.be);
    end else begin
      chk(got, "R10 response strobe seen", got, 1);
      chk(data == v.exp, "R5 R6 R7 read data", data, v.exp);
    end
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk(mem_cke == 1'b0,   "R1 CKE low in reset", mem_cke, 0);
    chk(mem_cs_n == 1'b1,  "R1 CS# high in reset", mem_cs_n, 1);
    chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
    chk(mem_dq_oe == 1'b0, "R1 bus released in reset", mem_dq_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cke == 1'b1, "R1 CKE high after reset", mem_cke, 1);
    begin
      int t = 0;
      while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    end
    chk(nop_pre >= INIT_CYC, "R2 NOP cycles before first command", nop_pre, INIT_CYC);
    chk(seq[0] == 3'b010 && seq_a10, "R3 first command PRECHARGE all", {seq[0], seq_a10}, 4'b0101);
    chk(seq[1] == 3'b001, "R3 second command REFRESH", seq[1], 3'b001);
    chk(seq[2] == 3'b001, "R3 third command REFRESH", seq[2], 3'b001);
    chk(seq[3] == 3'b000, "R3 fourth command LOAD MODE", seq[3], 3'b000);
    chk(mode_word == 13'(CL << 4) && mode_ba == 2'b00, "R3 mode word", {mode_ba, mode_word}, CL << 4);
    chk(req_ready == 1'b1, "R4 ready after start-up", req_ready, 1);

    for (int i = 0; i < NV; i++) access(vec_t'(VEC[i]));

    r0 = ref_cnt;
    repeat (1000) @(negedge clk);
    chk(ref_cnt - r0 >= 6 && ref_cnt - r0 <= 7, "R12 refresh rate", ref_cnt - r0, 6);
    chk(min_gap >= T_RC, "R12 REFRESH recovery spacing", min_gap, T_RC);

    chk(early == 0,   "R2 no access before ready", early, 0);
    chk(a10_bad == 0, "R8 auto-precharge bit", a10_bad, 0);
    chk(rcd_bad == 0 && rcd_seen == NV, "R9 ACTIVE to column spacing", rcd_bad, 0);
    chk(lat_bad == 0, "R10 read latency", lat_bad, 0);
    chk(rsp_cnt == rd_issued, "R10 one strobe per READ", rsp_cnt, rd_issued);
    chk(oe_bad == 0,  "R11 bus drive only in WRITE", oe_bad, 0);
    chk(seq_bad == 0, "R5 R6 command legality and open row", seq_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R4 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule